// File: doc/BRIEF.md
# SMIC Host Transaction Controller

This block runs one complete request/response exchange from the host side against a management controller. The controller is reached through a three-register port: a data register, a shared control/status register and a flags register. Software or a neighbouring block first fills a local request buffer, then asks for a transaction of a given length. The engine steps through the write phase byte by byte and then the read phase. It drives the busy-flag handshake itself and checks every status the controller reports. When the exchange ends it leaves the response in a local buffer.

Faults are handled inside the block. An unexpected status, a nonzero error byte or a stalled step restarts the whole exchange. After repeated faults the engine gives up and reports a hosed condition. A response that is longer than the buffer is drained from the controller and marked as truncated. While the engine is idle it keeps polling the flags and reports pending controller traffic on an attention output.

Top module: `smic_host_ctrl`

## Requirements
- R1: After reset, `done`, `hosed`, `attn`, `truncated`, `start_ack` and `start_err` are 0, and the engine is idle.
- R2: A `start` with `start_len` from 2 to MAX_REQ while idle gives a one-cycle `start_ack`. A `start` with any other length gives a one-cycle `start_err` and no transaction.
- R3: A `start` while a transaction is in progress gives `start_err` and does not disturb the running transaction.
- R4: The register addresses are 0 for data, 1 for control/status and 2 for flags. Each step writes the control code, then the data byte when one is due, then the flags register with bit 0 (busy) set. No register write is issued between that flags write and a later flags read that returns bit 0 clear.
- R5: Write phase control codes: 0x40 get-status; then, after status 0xC0, 0x41 with request byte 0. Each further byte goes out with 0x42, or with 0x43 for the last byte. Neither 0x42 nor 0x43 is issued until flags bit 6 (TX ready) reads 1, and the status must echo the previous code (0xC1 or 0xC2).
- R6: After status 0xC3 the data register must read 0x00. The engine then waits for flags bit 7 (RX ready) before it writes 0x44.
- R7: Read phase: status 0xC4 or 0xC5 with RX ready stores the data byte and issues 0x45. Status 0xC6 stores the last byte and issues 0x46. `done` pulses only when the final status is 0xC0 and the data register reads 0x00. `rsp_len` then gives the number of stored bytes, and the bytes read back through `rsp_raddr`/`rsp_rdata` one cycle after the address.
- R8: A wrong status or a nonzero error byte restarts the transaction from get-status. With MAX_RETRIES = 3, the fourth failure pulses `hosed` instead, and the engine returns to idle with no `done`.
- R9: If no step completes for TIMEOUT_US microseconds, counted in cycles of a CLK_FREQ_HZ clock, this counts as a failure under R8.
- R10: Response bytes beyond MAX_RSP are read from the controller and discarded. `truncated` is set and `rsp_len` stays at MAX_RSP.
- R11: While idle, `attn` is 1 when any of flags bits 4, 3 or 2 is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_we | input | 1 | Request buffer write enable |
| req_waddr | input | REQ_AW | Request buffer write address |
| req_wdata | input | 8 | Request buffer write byte |
| start | input | 1 | Begin a transaction |
| start_len | input | LEN_W | Request length in bytes |
| start_ack | output | 1 | Start accepted (pulse) |
| start_err | output | 1 | Start rejected (pulse) |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | 2 | Register address |
| bus_wdata | output | 8 | Register write data |
| bus_rdata | input | 8 | Register read data, one cycle after `bus_rd` |
| done | output | 1 | Transaction completed (pulse) |
| hosed | output | 1 | Retries exhausted (pulse) |
| attn | output | 1 | Idle and controller has pending traffic |
| rsp_len | output | RSP_LW | Stored response length |
| truncated | output | 1 | Response exceeded buffer |
| rsp_raddr | input | RSP_AW | Response buffer read address |
| rsp_rdata | output | 8 | Response buffer read byte |

## Verification
The bench builds the block with MAX_REQ and MAX_RSP set to 8, a 1 MHz nominal clock and a 200 µs timeout. With these values the stall window is 200 cycles. An 11-byte response then overflows the buffer, and a nine-byte request is an out-of-range length. The four timeouts that lead to a hosed report therefore fit in a short run. A controller model delays busy clearing, drops TX ready after each written byte, and delays RX ready after write-end. It can also inject error bytes and wrong ready statuses, or hold busy for ever.

// File: rtl/smic_pkg.sv
package smic_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_OPOK, PH_WSTART, PH_WNEXT, PH_WEND,
    PH_W2R, PH_RSTART, PH_RNEXT, PH_REND
  } phase_t;

  typedef enum logic [3:0] {
    ST_FLG_RD, ST_FLG_WT, ST_STS_RD, ST_STS_WT, ST_DAT_RD, ST_DAT_WT,
    ST_CTL_WR, ST_BYTE_WR, ST_FLG_WR
  } step_t;

  localparam logic [1:0] RA_DATA  = 2'd0;
  localparam logic [1:0] RA_CS    = 2'd1;
  localparam logic [1:0] RA_FLAGS = 2'd2;

  localparam int FB_BUSY = 0;
  localparam int FB_MSG  = 2;
  localparam int FB_EVT  = 3;
  localparam int FB_SMI  = 4;
  localparam int FB_TXR  = 6;
  localparam int FB_RXR  = 7;

  localparam logic [7:0] CC_STATUS = 8'h40;
  localparam logic [7:0] CC_WSTART = 8'h41;
  localparam logic [7:0] CC_WNEXT  = 8'h42;
  localparam logic [7:0] CC_WEND   = 8'h43;
  localparam logic [7:0] CC_RSTART = 8'h44;
  localparam logic [7:0] CC_RNEXT  = 8'h45;
  localparam logic [7:0] CC_REND   = 8'h46;
  localparam logic [7:0] SC_BIT    = 8'h80;
endpackage

// File: rtl/smic_ram.sv
module smic_ram #(
  parameter int DEPTH = 80,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smic_timer.sv
module smic_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(CYCLES + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || reload)      cnt <= W'(CYCLES);
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R9: the window never exceeds its programmed length
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst) cnt <= W'(CYCLES));
endmodule

// File: rtl/smic_host_ctrl.sv
module smic_host_ctrl
  import smic_pkg::*;
#(
  parameter int MAX_REQ     = 80,
  parameter int MAX_RSP     = 80,
  parameter int CLK_FREQ_HZ = 125_000_000,
  parameter int TIMEOUT_US  = 100_000,
  parameter int MAX_RETRIES = 3,
  localparam int REQ_AW = $clog2(MAX_REQ),
  localparam int LEN_W  = $clog2(MAX_REQ + 1),
  localparam int RSP_AW = $clog2(MAX_RSP),
  localparam int RSP_LW = $clog2(MAX_RSP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_we,
  input  logic [REQ_AW-1:0] req_waddr,
  input  logic [7:0]        req_wdata,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  output logic              start_ack,
  output logic              start_err,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [1:0]        bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              done,
  output logic              hosed,
  output logic              attn,
  output logic [RSP_LW-1:0] rsp_len,
  output logic              truncated,
  input  logic [RSP_AW-1:0] rsp_raddr,
  output logic [7:0]        rsp_rdata
);
  localparam int unsigned TMO_CYC = (CLK_FREQ_HZ / 1_000_000) * TIMEOUT_US;
  localparam int RET_W = $clog2(MAX_RETRIES + 1);

  phase_t            phase, nxt_phase;
  step_t             step;
  logic [7:0]        flags_q, ctl_q, req_byte;
  logic              byte_due, dat_store;
  logic [LEN_W-1:0]  wr_pos, wr_left, len_q;
  logic [RSP_LW-1:0] rd_pos;
  logic [RET_W-1:0]  retry_q;
  logic              tmo_exp, tmo_reload;
  logic              status_ok, fail, last_fail, start_ok, rsp_we;

  smic_ram #(.DEPTH(MAX_REQ), .AW(REQ_AW)) u_req_buf (
    .clk(clk), .we(req_we), .waddr(req_waddr), .wdata(req_wdata),
    .raddr(wr_pos[REQ_AW-1:0]), .rdata(req_byte)
  );

  assign rsp_we = (step == ST_DAT_WT) && dat_store && (rd_pos != RSP_LW'(MAX_RSP));

  smic_ram #(.DEPTH(MAX_RSP), .AW(RSP_AW)) u_rsp_buf (
    .clk(clk), .we(rsp_we), .waddr(rd_pos[RSP_AW-1:0]), .wdata(bus_rdata),
    .raddr(rsp_raddr), .rdata(rsp_rdata)
  );

  smic_timer #(.CYCLES(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .reload(tmo_reload), .run(phase != PH_IDLE),
    .expired(tmo_exp)
  );

  // status each phase expects to see echoed back
  always_comb begin
    case (phase)
      PH_OPOK:   status_ok = (bus_rdata == (SC_BIT | CC_STATUS));
      PH_WSTART: status_ok = (bus_rdata == (SC_BIT | CC_WSTART));
      PH_WNEXT:  status_ok = (bus_rdata == (SC_BIT | CC_WNEXT));
      PH_WEND:   status_ok = (bus_rdata == (SC_BIT | CC_WEND));
      PH_RSTART: status_ok = (bus_rdata == (SC_BIT | CC_RSTART));
      PH_RNEXT:  status_ok = (bus_rdata == (SC_BIT | CC_RNEXT)) ||
                             (bus_rdata == (SC_BIT | CC_REND));
      PH_REND:   status_ok = (bus_rdata == (SC_BIT | CC_STATUS));
      default:   status_ok = 1'b1;
    endcase
  end

  assign fail = ((step == ST_FLG_RD) && (phase != PH_IDLE) && tmo_exp) ||
                ((step == ST_STS_WT) && !status_ok) ||
                ((step == ST_DAT_WT) && !dat_store && (bus_rdata != 8'h00));
  assign last_fail = fail && (retry_q == RET_W'(MAX_RETRIES));
  assign start_ok  = start && (phase == PH_IDLE) &&
                     (start_len >= LEN_W'(2)) && (start_len <= LEN_W'(MAX_REQ));
  assign tmo_reload = start_ok || (fail && !last_fail) || (step == ST_FLG_WR) ||
                      ((step == ST_DAT_WT) && !dat_store && !fail && (phase == PH_WEND));

  // register port decode
  always_comb begin
    bus_rd    = (step == ST_FLG_RD) || (step == ST_STS_RD) || (step == ST_DAT_RD);
    bus_wr    = (step == ST_CTL_WR) || (step == ST_BYTE_WR) || (step == ST_FLG_WR);
    bus_addr  = RA_DATA;
    bus_wdata = 8'h00;
    case (step)
      ST_FLG_RD:  bus_addr = RA_FLAGS;
      ST_STS_RD:  bus_addr = RA_CS;
      ST_CTL_WR:  begin bus_addr = RA_CS;    bus_wdata = ctl_q; end
      ST_BYTE_WR: begin bus_addr = RA_DATA;  bus_wdata = req_byte; end
      ST_FLG_WR:  begin bus_addr = RA_FLAGS; bus_wdata = flags_q | 8'h01; end
      default: ;
    endcase
  end

  assign rsp_len = rd_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;  nxt_phase <= PH_IDLE;  step <= ST_FLG_RD;
      flags_q <= '0;  ctl_q <= '0;  byte_due <= 1'b0;  dat_store <= 1'b0;
      wr_pos <= '0;  wr_left <= '0;  len_q <= '0;  rd_pos <= '0;  retry_q <= '0;
      done <= 1'b0;  hosed <= 1'b0;  attn <= 1'b0;  truncated <= 1'b0;
      start_ack <= 1'b0;  start_err <= 1'b0;
    end else begin
      done <= 1'b0;  hosed <= 1'b0;
      start_ack <= start && start_ok;
      start_err <= start && !start_ok;
      if (start_ok) begin
        phase <= PH_START;  step <= ST_FLG_RD;  attn <= 1'b0;
        wr_pos <= '0;  wr_left <= start_len;  len_q <= start_len;
        rd_pos <= '0;  truncated <= 1'b0;  retry_q <= '0;
      end else if (fail) begin
        step <= ST_FLG_RD;
        if (last_fail) begin
          phase <= PH_IDLE;  hosed <= 1'b1;  retry_q <= '0;
        end else begin
          phase <= PH_START;  retry_q <= retry_q + 1'b1;
          wr_pos <= '0;  wr_left <= len_q;  rd_pos <= '0;  truncated <= 1'b0;
        end
      end else begin
        case (step)
          ST_FLG_RD: step <= ST_FLG_WT;
          ST_FLG_WT: begin
            flags_q <= bus_rdata;
            if (phase == PH_IDLE) begin
              attn <= bus_rdata[FB_SMI] | bus_rdata[FB_EVT] | bus_rdata[FB_MSG];
              step <= ST_FLG_RD;
            end else if (bus_rdata[FB_BUSY]) step <= ST_FLG_RD;
            else step <= ST_STS_RD;
          end
          ST_STS_RD: step <= ST_STS_WT;
          ST_STS_WT: begin
            byte_due <= 1'b0;  dat_store <= 1'b0;  step <= ST_FLG_RD;
            case (phase)
              PH_START: begin ctl_q <= CC_STATUS; nxt_phase <= PH_OPOK; step <= ST_CTL_WR; end
              PH_OPOK: begin
                ctl_q <= CC_WSTART; nxt_phase <= PH_WSTART; byte_due <= 1'b1; step <= ST_CTL_WR;
              end
              PH_WSTART, PH_WNEXT: if (flags_q[FB_TXR]) begin
                byte_due <= 1'b1;  step <= ST_CTL_WR;
                if (wr_left == LEN_W'(1)) begin ctl_q <= CC_WEND;  nxt_phase <= PH_WEND;  end
                else                      begin ctl_q <= CC_WNEXT; nxt_phase <= PH_WNEXT; end
              end
              PH_WEND, PH_REND: step <= ST_DAT_RD;
              PH_W2R: if (flags_q[FB_RXR]) begin
                ctl_q <= CC_RSTART; nxt_phase <= PH_RSTART; step <= ST_CTL_WR;
              end
              PH_RSTART: if (flags_q[FB_RXR]) begin
                ctl_q <= CC_RNEXT; nxt_phase <= PH_RNEXT; dat_store <= 1'b1; step <= ST_DAT_RD;
              end
              PH_RNEXT: if (bus_rdata == (SC_BIT | CC_REND)) begin
                ctl_q <= CC_REND; nxt_phase <= PH_REND; dat_store <= 1'b1; step <= ST_DAT_RD;
              end else if (flags_q[FB_RXR]) begin
                ctl_q <= CC_RNEXT; nxt_phase <= PH_RNEXT; dat_store <= 1'b1; step <= ST_DAT_RD;
              end
              default: ;
            endcase
          end
          ST_DAT_RD: step <= ST_DAT_WT;
          ST_DAT_WT: begin
            if (dat_store) begin
              if (rd_pos == RSP_LW'(MAX_RSP)) truncated <= 1'b1;
              else rd_pos <= rd_pos + 1'b1;
              step <= ST_CTL_WR;
            end else if (phase == PH_WEND) begin
              phase <= PH_W2R;  step <= ST_FLG_RD;
            end else begin
              phase <= PH_IDLE;  done <= 1'b1;  step <= ST_FLG_RD;
            end
          end
          ST_CTL_WR:  step <= byte_due ? ST_BYTE_WR : ST_FLG_WR;
          ST_BYTE_WR: begin
            wr_pos <= wr_pos + 1'b1;  wr_left <= wr_left - 1'b1;  step <= ST_FLG_WR;
          end
          ST_FLG_WR:  begin phase <= nxt_phase; step <= ST_FLG_RD; end
          default:    step <= ST_FLG_RD;
        endcase
      end
    end
  end

  // R4: every flags write-back raises busy
  a_r4_busy_wb: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_FLAGS) |-> bus_wdata[FB_BUSY]);
  // R5: only the defined control codes reach the control register
  a_r5_ctl_range: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_CS) |-> (bus_wdata >= CC_STATUS && bus_wdata <= CC_REND));
  // R2: a start is never both accepted and rejected
  a_r2_ack_xor: assert property (@(posedge clk) disable iff (rst) !(start_ack && start_err));
  // R3: start during a transaction is rejected next cycle
  a_r3_busy_reject: assert property (@(posedge clk) disable iff (rst)
    (start && phase != PH_IDLE) |=> start_err);
  // R11: attention only while idle
  a_r11_attn_idle: assert property (@(posedge clk) disable iff (rst) attn |-> (phase == PH_IDLE));
  // R10: stored length capped at buffer size
  a_r10_len_cap: assert property (@(posedge clk) disable iff (rst) rsp_len <= RSP_LW'(MAX_RSP));
  // R7/R8: completion and hosed are exclusive
  a_r7_done_excl: assert property (@(posedge clk) disable iff (rst) done |-> !hosed);
endmodule

// File: tb/smic_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module smic_host_ctrl_tb_top;
  localparam int MAX_REQ = 8, MAX_RSP = 8, TMO = 200;
  localparam int REQ_AW = 3, LEN_W = 4, RSP_AW = 3, RSP_LW = 4;

  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic req_we = 0; logic [REQ_AW-1:0] req_waddr = '0; logic [7:0] req_wdata = '0;
  logic start = 0; logic [LEN_W-1:0] start_len = '0;
  logic start_ack, start_err, bus_rd, bus_wr, done, hosed, attn, truncated;
  logic [1:0] bus_addr; logic [7:0] bus_wdata, rsp_rdata;
  logic [7:0] bus_rdata;
  logic [RSP_LW-1:0] rsp_len; logic [RSP_AW-1:0] rsp_raddr = '0;

  smic_host_ctrl #(.MAX_REQ(MAX_REQ), .MAX_RSP(MAX_RSP), .CLK_FREQ_HZ(1_000_000),
                   .TIMEOUT_US(TMO), .MAX_RETRIES(3)) dut_i (
    .clk(clk), .rst(rst), .req_we(req_we), .req_waddr(req_waddr), .req_wdata(req_wdata),
    .start(start), .start_len(start_len), .start_ack(start_ack), .start_err(start_err),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .done(done), .hosed(hosed), .attn(attn), .rsp_len(rsp_len),
    .truncated(truncated), .rsp_raddr(rsp_raddr), .rsp_rdata(rsp_rdata));

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  // ---------------- controller model ----------------
  logic [2:0] cfg_ev = 0; bit cfg_stuck = 0, cfg_bad_ready = 0, clr_log = 0;
  int cfg_err_cnt = 0, rsp_n = 2;
  logic [7:0] rsp_b [16];
  logic [7:0] cap [16]; logic [7:0] ctl_log [64];
  int cap_n, log_n, viol_busy, viol_ctl, wend_seen, ridx, bcnt, txcnt, rxcnt;
  logic m_busy, m_tx, m_rx; logic [7:0] m_ctl, m_status, m_data;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_tx <= 1; m_rx <= 0; m_ctl <= 0; m_status <= 8'hC0; m_data <= 0;
      cap_n <= 0; log_n <= 0; viol_busy <= 0; viol_ctl <= 0; wend_seen <= 0;
      ridx <= 0; bcnt <= 0; txcnt <= 0; rxcnt <= 0; bus_rdata <= 0;
    end else begin
      if (clr_log) begin log_n <= 0; viol_busy <= 0; viol_ctl <= 0; wend_seen <= 0; end
      if (bus_rd) case (bus_addr)
        2'd0: bus_rdata <= m_data;
        2'd1: bus_rdata <= m_status;
        2'd2: bus_rdata <= {m_rx, m_tx, 1'b0, cfg_ev, 1'b0, m_busy};
        default: bus_rdata <= 8'hFF;
      endcase
      if (bus_wr) begin
        if (m_busy) viol_busy <= viol_busy + 1;
        case (bus_addr)
          2'd1: begin
            m_ctl <= bus_wdata;
            if (log_n < 64) ctl_log[log_n] <= bus_wdata;
            log_n <= log_n + 1;
            if ((bus_wdata == 8'h42 || bus_wdata == 8'h43) && !m_tx) viol_ctl <= viol_ctl + 1;
            if (bus_wdata == 8'h44 && !m_rx) viol_ctl <= viol_ctl + 1;
            if (bus_wdata == 8'h41) cap_n <= 0;
          end
          2'd0: begin if (cap_n < 16) cap[cap_n] <= bus_wdata; cap_n <= cap_n + 1; end
          2'd2: if (bus_wdata[0]) begin m_busy <= 1; bcnt <= 2; end
          default: ;
        endcase
      end
      if (txcnt != 0) begin txcnt <= txcnt - 1; if (txcnt == 1) m_tx <= 1; end
      if (rxcnt != 0) begin rxcnt <= rxcnt - 1; if (rxcnt == 1) m_rx <= 1; end
      if (m_busy && !cfg_stuck && !bus_wr) begin
        if (bcnt != 0) bcnt <= bcnt - 1;
        else begin
          m_busy <= 0;
          case (m_ctl)
            8'h40: m_status <= cfg_bad_ready ? 8'h00 : 8'hC0;
            8'h41: begin m_status <= 8'hC1; m_tx <= 0; txcnt <= 3; end
            8'h42: begin m_status <= 8'hC2; m_tx <= 0; txcnt <= 3; end
            8'h43: begin
              m_status <= 8'hC3; m_data <= (wend_seen < cfg_err_cnt) ? 8'h05 : 8'h00;
              wend_seen <= wend_seen + 1; m_rx <= 0; rxcnt <= 5;
            end
            8'h44: begin m_status <= 8'hC4; m_data <= rsp_b[0]; ridx <= 1; end
            8'h45: begin
              m_data <= rsp_b[ridx]; m_status <= (ridx == rsp_n - 1) ? 8'hC6 : 8'hC5;
              ridx <= ridx + 1;
            end
            8'h46: begin m_status <= 8'hC0; m_data <= 0; m_rx <= 0; end
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q [$];
  int mon_done = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        for (int i = 0; i < int'(rsp_len); i++) begin
          rsp_raddr = RSP_AW'(i);
          @(negedge clk);
          if (exp_q.size() == 0) chk(0, "R7 scoreboard underflow", i, -1);
          else begin
            logic [7:0] e; e = exp_q.pop_front();
            chk(rsp_rdata == e, "R7 response byte", rsp_rdata, e);
          end
        end
        mon_done++;
      end
    end
  end

  logic [7:0] req_b [16];
  task automatic load_req(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); req_we = 1; req_waddr = REQ_AW'(i); req_wdata = req_b[i];
    end
    @(negedge clk); req_we = 0;
  endtask

  task automatic pulse_start(input int len, output bit ack, output bit err);
    @(negedge clk); start = 1; start_len = LEN_W'(len);
    @(negedge clk); start = 0; ack = start_ack; err = start_err;
  endtask

  // 1 = done, 2 = hosed, 0 = nothing
  task automatic wait_end(input int lim, output int res, output int cyc);
    res = 0; cyc = 0;
    while (res == 0 && cyc < lim) begin
      @(negedge clk); cyc++;
      if (done) res = 1; else if (hosed) res = 2;
    end
  endtask

  task automatic drive_txn(input int len, input int n, output int res, output int cyc);
    bit a, e; int md;
    for (int i = 0; i < len; i++) req_b[i] = 8'(8'h10 + 8'(i * 7) + 8'(n));
    for (int i = 0; i < n; i++) rsp_b[i] = 8'(8'hA0 ^ 8'(i * 13 + len));
    rsp_n = n;
    for (int i = 0; i < n && i < MAX_RSP; i++) exp_q.push_back(rsp_b[i]);
    load_req(len);
    @(negedge clk); clr_log = 1; @(negedge clk); clr_log = 0;
    md = mon_done;
    pulse_start(len, a, e);
    chk(a && !e, "R2 start accepted", a, 1);
    wait_end(20000, res, cyc);
    if (res == 1) while (mon_done == md) @(negedge clk);
  endtask

  int res, cyc;
  bit a, e;
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!done && !hosed && !truncated, "R1 reset outputs", {done, hosed, truncated}, 0);
    chk(!start_ack && !start_err && !attn, "R1 reset handshake", {start_ack, start_err, attn}, 0);

    // R11 attention
    for (int b = 0; b < 3; b++) begin
      cfg_ev = 3'(1 << b); repeat (8) @(negedge clk);
      chk(attn == 1, "R11 attn on flag", attn, 1);
    end
    cfg_ev = 0; repeat (8) @(negedge clk);
    chk(attn == 0, "R11 attn clear", attn, 0);

    // R2 length rejects
    pulse_start(1, a, e);  chk(e && !a, "R2 len 1 rejected", e, 1);
    pulse_start(9, a, e);  chk(e && !a, "R2 len 9 rejected", e, 1);
    repeat (20) @(negedge clk);
    chk(!done && !hosed, "R2 no txn after reject", done, 0);

    // main transaction 3 req / 4 rsp, with start while busy (R3)
    fork
      drive_txn(3, 4, res, cyc);
      begin
        repeat (30) @(negedge clk);
        start = 1; start_len = 4'd3; @(negedge clk); start = 0;
        chk(start_err && !start_ack, "R3 busy start rejected", start_err, 1);
      end
    join
    chk(res == 1, "R7 completion", res, 1);
    chk(rsp_len == 4 && !truncated, "R7 rsp_len", rsp_len, 4);
    chk(cap_n == 3 && cap[0] == req_b[0] && cap[1] == req_b[1] && cap[2] == req_b[2],
        "R5 request bytes", cap_n, 3);
    begin
      logic [7:0] ex [11] = '{8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h45, 8'h45, 8'h46, 0, 0};
      int bad = 0;
      for (int i = 0; i < 9; i++) if (ctl_log[i] != ex[i]) bad++;
      chk(log_n == 9 && bad == 0, "R5 R6 R7 control sequence", log_n, 9);
    end
    chk(viol_busy == 0, "R4 no write while busy", viol_busy, 0);
    chk(viol_ctl == 0, "R5 R6 ready flags honoured", viol_ctl, 0);

    // R5 boundary: two-byte request, two-byte response
    drive_txn(2, 2, res, cyc);
    chk(res == 1 && rsp_len == 2, "R5 len2 completion", rsp_len, 2);
    chk(log_n == 6 && ctl_log[2] == 8'h43, "R5 len2 goes straight to end", ctl_log[2], 8'h43);

    // R8 error byte once -> retried transaction
    cfg_err_cnt = 1;
    drive_txn(4, 3, res, cyc);
    begin
      int g = 0; for (int i = 0; i < log_n && i < 64; i++) if (ctl_log[i] == 8'h40) g++;
      chk(res == 1, "R8 retry completes", res, 1);
      chk(g == 2, "R8 restart from get-status", g, 2);
    end
    cfg_err_cnt = 0;

    // R10 truncation
    drive_txn(3, 11, res, cyc);
    chk(res == 1 && rsp_len == 8, "R10 rsp_len capped", rsp_len, 8);
    chk(truncated == 1, "R10 truncated flag", truncated, 1);

    // R8 hosed after four wrong ready statuses
    cfg_bad_ready = 1;
    @(negedge clk); clr_log = 1; @(negedge clk); clr_log = 0;
    pulse_start(3, a, e);
    wait_end(20000, res, cyc);
    begin
      int g = 0; for (int i = 0; i < log_n && i < 64; i++) if (ctl_log[i] == 8'h40) g++;
      chk(res == 2, "R8 hosed reported", res, 2);
      chk(g == 4, "R8 four attempts", g, 4);
    end
    cfg_bad_ready = 0;
    repeat (20) @(negedge clk);

    // R9 timeout: busy held
    cfg_stuck = 1;
    pulse_start(3, a, e);
    wait_end(20000, res, cyc);
    chk(res == 2, "R9 timeout leads to hosed", res, 2);
    chk(cyc >= 4 * TMO && cyc < 4 * TMO + 200, "R9 timeout window", cyc, 4 * TMO);
    cfg_stuck = 0;
    repeat (20) @(negedge clk);

    // recovery after hosed
    drive_txn(5, 5, res, cyc);
    chk(res == 1 && rsp_len == 5 && !truncated, "R8 recovery after hosed", rsp_len, 5);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule